// File: doc/BRIEF.md
# Outstanding Request Tracker for a Split-Transaction Snooping Bus

Each node on a split-transaction snooping bus holds an identical copy of this tracker. It follows every request placed on the shared bus, whether this node or another node issued it, until the response carrying the same tag comes back. The tracker has eight slots, and a three-bit tag selects the slot. Responses may come back in any order. Each response releases the slot its tag names.

The tracker also gates this node's own requests. A local request that targets a block already tracked is held. It is checked again every cycle and is granted as soon as the other request on that block completes. A local request that finds no free slot is refused with a NACK, and the requester tries again later. A granted request receives the lowest-numbered free tag. A request carrying write intent counts as committed in the cycle it is granted. A request seen on the bus always takes precedence over the local request in the same cycle.

Top module: `rqt_table`

## Requirements
- R1: After reset every slot is free, `loc_grant`, `loc_nack`, `loc_blocked`, `loc_commit`, `snp_nack` and `rsp_mine` are low, and the first granted local request receives tag 0.
- R2: A local request with no conflict, when at least one slot is free, is granted in the same cycle (`loc_grant`=1). `loc_tag` is the lowest-numbered free slot, and that slot is occupied from the next cycle on.
- R3: A local request whose block address equals that of any occupied slot raises `loc_blocked` and is not granted. It is granted in the first cycle in which no occupied slot matches, and this includes the cycle in which the matching slot's response arrives.
- R4: A local request with no conflict, when all eight slots are occupied, raises `loc_nack`. A slot released by a response in the same cycle counts as free.
- R5: In any cycle with `snp_valid`=1, the local request gets no outcome: `loc_grant`, `loc_nack` and `loc_blocked` all stay low.
- R6: An accepted snooped request occupies the slot named by `snp_tag` as a remote entry. Later local grants skip that slot, and local requests to its block are blocked.
- R7: `snp_nack` is raised when the snooped tag's slot is occupied or the snooped block matches an occupied slot. A refused snooped request changes no slot.
- R8: A response releases the slot named by `rsp_tag` regardless of order. A response naming a free slot changes nothing.
- R9: `loc_commit` is high exactly when a granted request has write intent. Command encoding: 0 read, 1 read-exclusive, 2 upgrade, 3 write-back. Codes 1 to 3 carry write intent.
- R10: `rsp_mine` is high in the cycle a response names an occupied slot that holds a locally issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req | input | 1 | Local request pending |
| loc_addr | input | ADDR_W | Block address of the local request |
| loc_cmd | input | 2 | Command of the local request |
| snp_valid | input | 1 | Request observed in the bus request phase |
| snp_tag | input | 3 | Tag carried by the observed request |
| snp_addr | input | ADDR_W | Block address of the observed request |
| rsp_valid | input | 1 | Response phase active |
| rsp_tag | input | 3 | Tag of the completing request |
| loc_grant | output | 1 | Local request granted this cycle |
| loc_tag | output | 3 | Tag given to the granted request |
| loc_nack | output | 1 | Local request refused, table full |
| loc_blocked | output | 1 | Local request held by a same-block conflict |
| loc_commit | output | 1 | Granted request with write intent committed |
| snp_nack | output | 1 | Observed request refused |
| rsp_mine | output | 1 | Response belongs to a local request |

## Verification
On every cycle the assertions check the following. At most one local outcome is given. A bus request suppresses the local outcome. A grant lands on a slot that is free or is being released. A NACK happens only when the table is full. A released or granted slot holds the expected occupancy in the next cycle. Other behaviour needs the bench's scenarios, because only a history of grants, snoops and responses can show it. This covers lowest-free tag order, the same-cycle release bypass for conflicts and full refusals, responses that complete out of order, snooped entries steering later allocation, and ignored responses to free tags.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

    localparam int TAG_W   = 3;
    localparam int NUM_ENT = 1 << TAG_W;

    typedef enum logic [1:0] {
        CMD_READ    = 2'd0,
        CMD_READX   = 2'd1,
        CMD_UPGRADE = 2'd2,
        CMD_WRBACK  = 2'd3
    } bus_cmd_e;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [NUM_ENT-1:0] slot_vec_t;

    // outcome for the local requester in one cycle
    typedef struct packed {
        logic grant;
        logic nack;
        logic blocked;
    } loc_outcome_t;

    function automatic logic has_write_intent(bus_cmd_e c);
        return c != CMD_READ;
    endfunction

    function automatic slot_vec_t tag_to_mask(tag_t t);
        return slot_vec_t'(1) << t;
    endfunction

endpackage

// File: rtl/rqt_entry_bank.sv
module rqt_entry_bank
    import rqt_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tag_t              wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_local,
    input  slot_vec_t         clr_mask,
    input  logic [ADDR_W-1:0] cmp_a,
    input  logic [ADDR_W-1:0] cmp_b,
    output slot_vec_t         valid,
    output slot_vec_t         live,
    output slot_vec_t         local_vec,
    output slot_vec_t         hit_a,
    output slot_vec_t         hit_b
);

    logic [ADDR_W-1:0] addr_q [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid[i]     <= 1'b0;
                local_vec[i] <= 1'b0;
                addr_q[i]    <= '0;
            end else if (wr_en && wr_idx == tag_t'(i)) begin
                valid[i]     <= 1'b1;
                local_vec[i] <= wr_local;
                addr_q[i]    <= wr_addr;
            end else if (clr_mask[i]) begin
                valid[i]     <= 1'b0;
            end
        end

        // a slot being released this cycle no longer counts
        assign live[i]  = valid[i] && !clr_mask[i];
        assign hit_a[i] = live[i] && addr_q[i] == cmp_a;
        assign hit_b[i] = live[i] && addr_q[i] == cmp_b;
    end

endmodule

// File: rtl/rqt_alloc.sv
module rqt_alloc
    import rqt_pkg::*;
(
    input  slot_vec_t busy,
    output logic      any_free,
    output tag_t      free_idx
);

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = tag_t'(i);
            end
        end
    end

endmodule

// File: rtl/rqt_ctrl.sv
module rqt_ctrl
    import rqt_pkg::*;
(
    input  logic         loc_req,
    input  bus_cmd_e     loc_cmd,
    input  logic         snp_valid,
    input  tag_t         snp_tag,
    input  slot_vec_t    live,
    input  slot_vec_t    loc_hit,
    input  slot_vec_t    snp_hit,
    input  logic         any_free,
    input  tag_t         free_idx,
    output loc_outcome_t outcome,
    output logic         commit,
    output logic         snp_refuse,
    output logic         wr_en,
    output tag_t         wr_idx,
    output logic         wr_local
);

    logic snp_accept;
    logic loc_turn;

    always_comb begin
        snp_refuse = snp_valid && (live[snp_tag] || (|snp_hit));
        snp_accept = snp_valid && !snp_refuse;

        // bus traffic is serviced ahead of the local requester
        loc_turn        = loc_req && !snp_valid;
        outcome.blocked = loc_turn && (|loc_hit);
        outcome.nack    = loc_turn && !(|loc_hit) && !any_free;
        outcome.grant   = loc_turn && !(|loc_hit) && any_free;
        commit          = outcome.grant && has_write_intent(loc_cmd);

        wr_en    = snp_accept || outcome.grant;
        wr_idx   = snp_accept ? snp_tag : free_idx;
        wr_local = !snp_accept;
    end

endmodule

// File: rtl/rqt_table.sv
module rqt_table
    import rqt_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_req,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [1:0]        loc_cmd,
    input  logic              snp_valid,
    input  logic [2:0]        snp_tag,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_tag,
    output logic              loc_grant,
    output logic [2:0]        loc_tag,
    output logic              loc_nack,
    output logic              loc_blocked,
    output logic              loc_commit,
    output logic              snp_nack,
    output logic              rsp_mine
);

    slot_vec_t    ent_valid;
    slot_vec_t    ent_live;
    slot_vec_t    ent_local;
    slot_vec_t    loc_hit;
    slot_vec_t    snp_hit;
    slot_vec_t    clr_mask;
    logic         any_free;
    tag_t         free_idx;
    loc_outcome_t outcome;
    logic         wr_en;
    tag_t         wr_idx;
    logic         wr_local;

    assign clr_mask = rsp_valid ? tag_to_mask(rsp_tag) : '0;

    rqt_entry_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_addr   (wr_local ? loc_addr : snp_addr),
        .wr_local  (wr_local),
        .clr_mask  (clr_mask),
        .cmp_a     (loc_addr),
        .cmp_b     (snp_addr),
        .valid     (ent_valid),
        .live      (ent_live),
        .local_vec (ent_local),
        .hit_a     (loc_hit),
        .hit_b     (snp_hit)
    );

    rqt_alloc u_alloc (
        .busy     (ent_live),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    rqt_ctrl u_ctrl (
        .loc_req    (loc_req),
        .loc_cmd    (bus_cmd_e'(loc_cmd)),
        .snp_valid  (snp_valid),
        .snp_tag    (snp_tag),
        .live       (ent_live),
        .loc_hit    (loc_hit),
        .snp_hit    (snp_hit),
        .any_free   (any_free),
        .free_idx   (free_idx),
        .outcome    (outcome),
        .commit     (loc_commit),
        .snp_refuse (snp_nack),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_local   (wr_local)
    );

    assign loc_grant   = outcome.grant;
    assign loc_nack    = outcome.nack;
    assign loc_blocked = outcome.blocked;
    assign loc_tag     = outcome.grant ? free_idx : '0;
    assign rsp_mine    = rsp_valid && ent_valid[rsp_tag] && ent_local[rsp_tag];

endmodule

// File: rtl/rqt_table_chk.sv
module rqt_table_chk
    import rqt_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      loc_req,
    input logic      loc_grant,
    input logic [2:0] loc_tag,
    input logic      loc_nack,
    input logic      loc_blocked,
    input logic      loc_commit,
    input logic      snp_valid,
    input logic      snp_nack,
    input logic [2:0] snp_tag,
    input logic      rsp_valid,
    input logic [2:0] rsp_tag,
    input slot_vec_t ent_valid
);

    tag_t rsp_tag_q;
    tag_t loc_tag_q;
    logic rsp_kill_q;
    logic grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_tag_q  <= '0;
            loc_tag_q  <= '0;
            rsp_kill_q <= 1'b0;
            grant_q    <= 1'b0;
        end else begin
            rsp_tag_q  <= rsp_tag;
            loc_tag_q  <= loc_tag;
            grant_q    <= loc_grant;
            rsp_kill_q <= rsp_valid
                && !(loc_grant && loc_tag == rsp_tag)
                && !(snp_valid && !snp_nack && snp_tag == rsp_tag);
        end
    end

    // R2 / R3 / R4: at most one outcome, and only for a pending request
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_grant, loc_nack, loc_blocked}));
    a_r2_needs_req: assert property (@(posedge clk) disable iff (rst)
        (loc_grant || loc_nack || loc_blocked) |-> loc_req);
    // R2: a grant lands on a free or releasing slot, occupied next cycle
    a_r2_grant_free_slot: assert property (@(posedge clk) disable iff (rst)
        loc_grant |-> (!ent_valid[loc_tag] || (rsp_valid && rsp_tag == loc_tag)));
    a_r2_slot_taken: assert property (@(posedge clk) disable iff (rst)
        grant_q |-> ent_valid[loc_tag_q]);
    // R4: refusal only when every slot is held
    a_r4_nack_full: assert property (@(posedge clk) disable iff (rst)
        loc_nack |-> (&ent_valid));
    // R5: bus request takes the cycle
    a_r5_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !(loc_grant || loc_nack || loc_blocked));
    // R8: a response frees its slot unless refilled in the same cycle
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        rsp_kill_q |-> !ent_valid[rsp_tag_q]);
    // R9: commit only with a grant
    a_r9_commit_grant: assert property (@(posedge clk) disable iff (rst)
        loc_commit |-> loc_grant);

endmodule

bind rqt_table rqt_table_chk u_chk (.*);

// File: tb/rqt_table_bench.sv
`timescale 1ns/1ps
module rqt_table_bench;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          loc_req;
    logic [AW-1:0] loc_addr;
    logic [1:0]    loc_cmd;
    logic          snp_valid;
    logic [2:0]    snp_tag;
    logic [AW-1:0] snp_addr;
    logic          rsp_valid;
    logic [2:0]    rsp_tag;
    logic          loc_grant, loc_nack, loc_blocked, loc_commit, snp_nack, rsp_mine;
    logic [2:0]    loc_tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rqt_table #(.ADDR_W(AW)) u_rqt_table (.*);

    // reference model state
    logic [7:0]    m_valid;
    logic [7:0]    m_local;
    logic [AW-1:0] m_addr [8];
    logic e_grant, e_nack, e_blocked, e_commit, e_snack, e_mine;
    logic [2:0] e_tag;
    logic [7:0] e_live;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_valid = '0;
        m_local = '0;
        for (int i = 0; i < 8; i++) m_addr[i] = '0;
    endtask

    task automatic model_eval();
        logic lhit, shit, turn, found;
        e_live = m_valid & ~(rsp_valid ? (8'd1 << rsp_tag) : 8'd0);
        e_mine = rsp_valid && m_valid[rsp_tag] && m_local[rsp_tag];
        lhit = 1'b0; shit = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (e_live[i] && m_addr[i] == loc_addr) lhit = 1'b1;
            if (e_live[i] && m_addr[i] == snp_addr) shit = 1'b1;
        end
        e_snack = snp_valid && (e_live[snp_tag] || shit);
        found = 1'b0; e_tag = 3'd0;
        for (int i = 0; i < 8; i++)
            if (!found && !e_live[i]) begin found = 1'b1; e_tag = 3'(i); end
        turn      = loc_req && !snp_valid;
        e_blocked = turn && lhit;
        e_nack    = turn && !lhit && !found;
        e_grant   = turn && !lhit && found;
        if (!e_grant) e_tag = 3'd0;
        e_commit  = e_grant && loc_cmd != 2'd0;
    endtask

    task automatic model_commit();
        m_valid = e_live;
        if (snp_valid && !e_snack) begin
            m_valid[snp_tag] = 1'b1; m_local[snp_tag] = 1'b0; m_addr[snp_tag] = snp_addr;
        end
        if (e_grant) begin
            m_valid[e_tag] = 1'b1; m_local[e_tag] = 1'b1; m_addr[e_tag] = loc_addr;
        end
    endtask

    // drive at negedge, compare before the next rising edge
    task automatic step(input logic lr, input int la, input int lc,
                        input logic sv, input int st, input int sa,
                        input logic rv, input int rt);
        @(negedge clk);
        loc_req = lr; loc_addr = AW'(la); loc_cmd = 2'(lc);
        snp_valid = sv; snp_tag = 3'(st); snp_addr = AW'(sa);
        rsp_valid = rv; rsp_tag = 3'(rt);
        #2;
        model_eval();
        check("R2", "loc_grant", int'(loc_grant), int'(e_grant));
        check("R2", "loc_tag", int'(loc_tag), int'(e_tag));
        check("R4", "loc_nack", int'(loc_nack), int'(e_nack));
        check("R3", "loc_blocked", int'(loc_blocked), int'(e_blocked));
        check("R9", "loc_commit", int'(loc_commit), int'(e_commit));
        check("R7", "snp_nack", int'(snp_nack), int'(e_snack));
        check("R10", "rsp_mine", int'(rsp_mine), int'(e_mine));
        model_commit();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        loc_req = 0; loc_addr = '0; loc_cmd = '0; snp_valid = 0; snp_tag = '0;
        snp_addr = '0; rsp_valid = 0; rsp_tag = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1: idle after reset
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check("R1", "idle outputs", int'({loc_grant, loc_nack, loc_blocked, loc_commit, snp_nack, rsp_mine}), 0);
        // R1 / R9: first grant tag 0, read does not commit
        step(1, 'h10, 0, 0, 0, 0, 0, 0);
        check("R1", "first tag", int'(loc_tag), 0);
        check("R9", "read commit", int'(loc_commit), 0);
        // R2 / R9: next tag 1, read-exclusive commits
        step(1, 'h11, 1, 0, 0, 0, 0, 0);
        check("R2", "second tag", int'(loc_tag), 1);
        check("R9", "readx commit", int'(loc_commit), 1);
        // R3: conflict held across cycles
        step(1, 'h10, 2, 0, 0, 0, 0, 0);
        check("R3", "blocked", int'(loc_blocked), 1);
        step(1, 'h10, 2, 0, 0, 0, 0, 0);
        check("R3", "still blocked", int'(loc_grant), 0);
        // R3 / R10: release bypass grants same cycle, response is local
        step(1, 'h10, 2, 0, 0, 0, 1, 0);
        check("R3", "bypass grant", int'(loc_grant), 1);
        check("R3", "bypass tag", int'(loc_tag), 0);
        check("R10", "local response", int'(rsp_mine), 1);
        // R8: response to a free slot ignored, next tag is 2
        step(0, 0, 0, 0, 0, 0, 1, 5);
        check("R10", "free slot response", int'(rsp_mine), 0);
        for (int k = 0; k < 6; k++) step(1, 'h20 + k, 3, 0, 0, 0, 0, 0);
        check("R8", "last fill tag", int'(loc_tag), 7);
        // R4: full table refuses
        step(1, 'h30, 0, 0, 0, 0, 0, 0);
        check("R4", "nack when full", int'(loc_nack), 1);
        // R8 / R4: out-of-order release of slot 3 admits the retry
        step(1, 'h30, 0, 0, 0, 0, 1, 3);
        check("R4", "grant on release", int'(loc_tag), 3);
        // R7: snooped tag occupied
        step(0, 0, 0, 1, 4, 'h40, 0, 0);
        check("R7", "busy tag nack", int'(snp_nack), 1);
        step(0, 0, 0, 0, 0, 0, 1, 6);
        // R7: snooped block conflict
        step(0, 0, 0, 1, 6, 'h11, 0, 0);
        check("R7", "block conflict nack", int'(snp_nack), 1);
        // R5 / R6: accepted snoop wins the cycle
        step(1, 'h40, 0, 1, 6, 'h40, 0, 0);
        check("R5", "no local outcome", int'({loc_grant, loc_nack, loc_blocked}), 0);
        check("R6", "snoop accepted", int'(snp_nack), 0);
        step(1, 'h40, 0, 0, 0, 0, 0, 0);
        check("R6", "blocked by remote", int'(loc_blocked), 1);
        step(0, 0, 0, 0, 0, 0, 1, 6);
        check("R10", "remote response", int'(rsp_mine), 0);
        // R6: freed slot 6 taken by a local grant, slot 2 via snoop then skipped
        step(0, 0, 0, 0, 0, 0, 1, 2);
        step(0, 0, 0, 1, 2, 'h50, 0, 0);
        step(1, 'h51, 0, 0, 0, 0, 0, 0);
        check("R6", "skip snooped slot", int'(loc_tag), 6);

        // random traffic against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 9), $urandom_range(0, 3),
                 $urandom_range(0, 4) == 0, $urandom_range(0, 7), $urandom_range(0, 9),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 7));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule